// File: doc/BRIEF.md
# Network Status Pin and Suspend Controller

This block holds a small self-control register for a network interface and uses it to drive three active-low status pins and a software suspend state. The activity pin goes low whenever a frame is sent or received, or a collision is seen. It stays low as a stretched pulse that restarts on every new event. The link pin and the bus-status pin each have two modes. In chip-driven mode they show link status or receive-event reads. In host-driven mode they output a level taken from the register.

The host puts the block into suspend by setting the suspend field. While suspended, the activity stretcher and the bus-status path are held inactive. The control register keeps its contents and ignores further register writes. Any write strobe to the block's I/O space ends suspend and its data is thrown away. The register then clears, and a one-cycle request starts the chip's reset and initialization sequence. An asynchronous hardware reset always leaves suspend.

The stretch length is derived from the clock frequency, so a test build can shorten it.

Top module: `stat_led_susp`

## Requirements
- R1: After hardware reset the register is clear, so both pins are chip-driven. `act_led_no` and `bus_stat_no` are high, `suspended_o` and `init_req_o` are low, and `link_led_no` follows the link input.
- R2: A tx, rx or collision event sampled on edge N drives `act_led_no` low after edge N. It stays low until edge N+S, where S = CLK_HZ/1e6 * STRETCH_US. A later event restarts the count from that event's edge.
- R3: With the pin-0 host field clear, `link_led_no` is the inverse of `link_ok_i` after a LINK_SYNC-stage (default 2) synchronizer.
- R4: The write data layout is bit0 suspend, bit1 pin-0 host mode, bit2 pin-1 host mode, bit3 pin-0 level, bit4 pin-1 level. With bit1 set, `link_led_no` is low when bit3 is 1 and high when bit3 is 0, from the edge that stores the write.
- R5: With bit2 clear, each `rxevt_rd_i` strobe sampled on edge N drives `bus_stat_no` low for the cycle after edge N only. Back-to-back strobes keep it low.
- R6: With bit2 set, `bus_stat_no` is low when bit4 is 1 and high when bit4 is 0. A strobe in the same cycle as a register write follows the newly written mode.
- R7: A register write with bit0 set, made while not suspended, raises `suspended_o` after that edge.
- R8: While suspended, `act_led_no` is high and its stretch count is cleared. In chip mode `bus_stat_no` is high. Events and strobes have no effect.
- R9: While suspended, a register write without `io_wr_i` changes no register field.
- R10: An `io_wr_i` sampled while suspended clears `suspended_o` and the whole register after that edge. `init_req_o` is high for exactly that one following cycle, and any register write data in that cycle is discarded. `io_wr_i` has no effect when not suspended.
- R11: Asserting `rst_ni` while suspended clears `suspended_o` at once and returns the register to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| tx_evt_i | input | 1 | Transmit activity pulse |
| rx_evt_i | input | 1 | Receive activity pulse |
| col_evt_i | input | 1 | Collision pulse |
| link_ok_i | input | 1 | Valid link pulses detected (asynchronous level) |
| rxevt_rd_i | input | 1 | Host read strobe of the receive-event register |
| reg_we_i | input | 1 | Self-control register write enable |
| reg_wdata_i | input | 5 | Self-control write data (layout in R4) |
| io_wr_i | input | 1 | Host write strobe to the block's I/O space |
| act_led_no | output | 1 | Activity LED, active low |
| link_led_no | output | 1 | Link LED or host pin 0, active low |
| bus_stat_no | output | 1 | Bus-status or host pin 1, active low |
| suspended_o | output | 1 | Software suspend active |
| init_req_o | output | 1 | One-cycle reset-and-initialize request |

## Verification
Some relations are checked on every cycle. An event outside suspend pulls the activity pin low on the next cycle. Suspend keeps the activity pin and the chip-mode bus-status pin high. A chip-mode bus-status low always follows a strobe. A host-mode write sets the pin level on the next cycle. Suspend entry and wake behave as specified, and register writes during suspend leave the register unchanged.

Only the directed scenarios can show the exact stretch length and restart point, the synchronizer latency on the link pin, strobe and mode-change collisions, and that a wake write's data never reaches the pins. Hardware reset in the middle of suspend is also covered only by a scenario.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef struct packed {
    logic p1_lvl;
    logic p0_lvl;
    logic p1_host;
    logic p0_host;
    logic susp;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/slc_ctrl_reg.sv
module slc_ctrl_reg
  import slc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              io_wr_i,
  output ctrl_t             ctrl_o,
  output logic              init_req_o
);
  ctrl_t ctrl_q;
  logic  init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      init_q <= 1'b0;
    end else begin
      init_q <= 1'b0;
      if (ctrl_q.susp) begin
        // wake write: data dropped, register cleared for re-init
        if (io_wr_i) begin
          ctrl_q <= '0;
          init_q <= 1'b1;
        end
      end else if (we_i) begin
        ctrl_q <= ctrl_t'(wdata_i);
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign init_req_o = init_q;
endmodule

// File: rtl/slc_act_stretch.sv
module slc_act_stretch #(
  parameter int unsigned STRETCH_CYC = 300000,
  localparam int unsigned CNT_W      = $clog2(STRETCH_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic hold_i,
  output logic led_no
);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(STRETCH_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (hold_i)          cnt_q <= '0;
    else if (evt_i)           cnt_q <= LOAD_V;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign led_no = hold_i | (cnt_q == '0);
endmodule

// File: rtl/slc_pin_sel.sv
module slc_pin_sel #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic status_i,
  input  logic hold_i,
  input  logic host_en_i,
  input  logic host_lvl_i,
  output logic pin_no
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pipe_q <= '0;
        else if (hold_i) pipe_q <= '0;
        else             pipe_q <= status_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pipe_q <= '0;
        else if (hold_i) pipe_q <= '0;
        else             pipe_q <= {pipe_q[STAGES-2:0], status_i};
      end
    end
  endgenerate

  assign pin_no = host_en_i ? ~host_lvl_i : ~(pipe_q[STAGES-1] & ~hold_i);
endmodule

// File: rtl/stat_led_susp.sv
module stat_led_susp
  import slc_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned STRETCH_US = 6000,
  parameter int unsigned LINK_SYNC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_evt_i,
  input  logic              rx_evt_i,
  input  logic              col_evt_i,
  input  logic              link_ok_i,
  input  logic              rxevt_rd_i,
  input  logic              reg_we_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  input  logic              io_wr_i,
  output logic              act_led_no,
  output logic              link_led_no,
  output logic              bus_stat_no,
  output logic              suspended_o,
  output logic              init_req_o
);
  localparam int unsigned TICKS_US    = CLK_HZ / 1_000_000;
  localparam int unsigned STRETCH_CYC = TICKS_US * STRETCH_US;

  ctrl_t ctrl_q;
  logic  susp;
  logic  act_evt;

  assign susp    = ctrl_q.susp;
  assign act_evt = tx_evt_i | rx_evt_i | col_evt_i;

  slc_ctrl_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .io_wr_i    (io_wr_i),
    .ctrl_o     (ctrl_q),
    .init_req_o (init_req_o)
  );

  slc_act_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_act (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (act_evt),
    .hold_i (susp),
    .led_no (act_led_no)
  );

  slc_pin_sel #(.STAGES(LINK_SYNC)) u_pin0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .status_i   (link_ok_i),
    .hold_i     (1'b0),
    .host_en_i  (ctrl_q.p0_host),
    .host_lvl_i (ctrl_q.p0_lvl),
    .pin_no     (link_led_no)
  );

  slc_pin_sel #(.STAGES(1)) u_pin1 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .status_i   (rxevt_rd_i),
    .hold_i     (susp),
    .host_en_i  (ctrl_q.p1_host),
    .host_lvl_i (ctrl_q.p1_lvl),
    .pin_no     (bus_stat_no)
  );

  assign suspended_o = susp;
endmodule

// File: rtl/stat_led_susp_chk.sv
module stat_led_susp_chk
  import slc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_evt_i,
  input logic              rx_evt_i,
  input logic              col_evt_i,
  input logic              rxevt_rd_i,
  input logic              reg_we_i,
  input logic [CTRL_W-1:0] reg_wdata_i,
  input logic              io_wr_i,
  input logic              act_led_no,
  input logic              link_led_no,
  input logic              bus_stat_no,
  input logic              suspended_o,
  input logic              init_req_o,
  input ctrl_t             ctrl_q
);
  assert_act_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tx_evt_i || rx_evt_i || col_evt_i) && !suspended_o) |=> (!act_led_no || suspended_o));

  assert_pin0_host_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !suspended_o && reg_wdata_i[1]) |=> (link_led_no != $past(reg_wdata_i[3])));

  assert_bus_after_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_stat_no && !ctrl_q.p1_host) |-> $past(rxevt_rd_i));

  assert_pin1_host_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !suspended_o && reg_wdata_i[2]) |=> (bus_stat_no != $past(reg_wdata_i[4])));

  assert_enter_susp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !suspended_o && reg_wdata_i[0]) |=> suspended_o);

  assert_quiet_in_susp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspended_o |-> (act_led_no && (ctrl_q.p1_host || bus_stat_no)));

  assert_write_dropped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspended_o && reg_we_i && !io_wr_i) |=> $stable(ctrl_q));

  assert_wake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspended_o && io_wr_i) |=> (init_req_o && !suspended_o && ctrl_q == '0));

  assert_init_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_o |=> !init_req_o);

  assert_init_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_req_o) |-> $fell(suspended_o));
endmodule

bind stat_led_susp stat_led_susp_chk u_chk (.*);

// File: tb/sim_stat_led_susp.sv
`timescale 1ns/1ps
module sim_stat_led_susp;
  localparam int unsigned S = 20;  // 1 MHz-derived ticks x 20 us

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx = 0, rx = 0, col = 0, link_ok = 0, rd = 0, we = 0, io_wr = 0;
  logic [4:0] wd = '0;
  logic act_n, link_n, bus_n, susp, init;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  stat_led_susp #(.CLK_HZ(1_000_000), .STRETCH_US(S), .LINK_SYNC(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_evt_i(tx), .rx_evt_i(rx), .col_evt_i(col),
    .link_ok_i(link_ok), .rxevt_rd_i(rd), .reg_we_i(we), .reg_wdata_i(wd),
    .io_wr_i(io_wr), .act_led_no(act_n), .link_led_no(link_n), .bus_stat_no(bus_n),
    .suspended_o(susp), .init_req_o(init)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] v);
    we = 1; wd = v; tick(); we = 0; wd = '0;
  endtask

  task automatic t_reset();
    chk(act_n, 1, "R1 act"); chk(bus_n, 1, "R1 bus"); chk(link_n, 1, "R1 link");
    chk(susp, 0, "R1 susp"); chk(init, 0, "R1 init");
  endtask

  task automatic t_stretch();
    tx = 1; tick(); tx = 0;
    chk(act_n, 0, "R2 low after tx");
    repeat (S - 1) tick();
    chk(act_n, 0, "R2 low at S-1");
    tick();
    chk(act_n, 1, "R2 high at S");
    rx = 1; tick(); rx = 0;
    repeat (9) tick();
    col = 1; tick(); col = 0;
    repeat (S - 1) tick();
    chk(act_n, 0, "R2 retrigger still low");
    tick();
    chk(act_n, 1, "R2 retrigger end");
  endtask

  task automatic t_link();
    link_ok = 1; tick();
    chk(link_n, 1, "R3 sync stage 1");
    tick();
    chk(link_n, 0, "R3 link low");
    link_ok = 0; tick(); tick();
    chk(link_n, 1, "R3 link high");
  endtask

  task automatic t_pin0_host();
    wr(5'b01010);
    chk(link_n, 0, "R4 host level 1");
    link_ok = 1; tick(); tick();
    wr(5'b00010);
    chk(link_n, 1, "R4 host level 0");
    wr(5'b00000);
    chk(link_n, 0, "R4 back to chip mode");
  endtask

  task automatic t_bus();
    rd = 1; tick(); rd = 0;
    chk(bus_n, 0, "R5 low after strobe");
    tick();
    chk(bus_n, 1, "R5 one cycle only");
    rd = 1; tick(); tick(); rd = 0;
    chk(bus_n, 0, "R5 back-to-back");
    tick();
    chk(bus_n, 1, "R5 release");
  endtask

  task automatic t_pin1_host();
    wr(5'b10100);
    chk(bus_n, 0, "R6 host level 1");
    wr(5'b00100);
    chk(bus_n, 1, "R6 host level 0");
    rd = 1; tick(); rd = 0;
    chk(bus_n, 1, "R6 strobe ignored in host mode");
    wr(5'b00000);
    we = 1; wd = 5'b00100; rd = 1; tick(); we = 0; wd = '0; rd = 0;
    chk(bus_n, 1, "R6 strobe follows new host mode");
    wr(5'b10100);
    we = 1; wd = 5'b00000; rd = 1; tick(); we = 0; rd = 0;
    chk(bus_n, 0, "R6 strobe follows new chip mode");
    tick();
  endtask

  task automatic t_suspend();
    io_wr = 1; tick(); io_wr = 0;
    chk(init, 0, "R10 io write ignored when awake");
    wr(5'b00001);
    chk(susp, 1, "R7 suspended");
    tx = 1; tick(); tx = 0;
    chk(act_n, 1, "R8 act held high");
    rd = 1; tick(); rd = 0;
    chk(bus_n, 1, "R8 bus held high");
    wr(5'b01010);
    chk(link_n, 0, "R9 write dropped, link chip mode");
    chk(susp, 1, "R9 still suspended");
    we = 1; wd = 5'b10100; io_wr = 1; tick(); we = 0; wd = '0; io_wr = 0;
    chk(susp, 0, "R10 woke");
    chk(init, 1, "R10 init pulse");
    chk(bus_n, 1, "R10 wake data discarded");
    chk(act_n, 1, "R10 act idle after wake");
    tick();
    chk(init, 0, "R10 init single cycle");
  endtask

  task automatic t_hw_reset();
    wr(5'b10101);
    chk(susp, 1, "R11 suspended before reset");
    #3 rst_n = 0; #1;
    chk(susp, 0, "R11 async exit");
    chk(bus_n, 1, "R11 register cleared");
    tick(); rst_n = 1; tick();
    chk(init, 0, "R11 no init request");
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_stretch();
    t_link();
    t_pin0_host();
    t_bus();
    t_pin1_host();
    t_suspend();
    t_hw_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule